// File: doc/BRIEF.md
# Color Subcarrier Oscillator and Burst Window Generator

This block produces the color subcarrier phase for a composite video encoder. It uses a phase-accumulating oscillator clocked by the system sample clock. The accumulator step is fixed at elaboration for each scan standard. For the 525-line standard the step follows from the exact 315/88 MHz subcarrier. For the 625-line standard it follows from the line rate multiplied by (1135/4 + 1/625), which is 17734475/4 Hz. The accumulator runs without a break across lines and across standard changes. The line-start strobe never resets it, so the phase relationship to line timing stays as the standards define it.

On every active line, the block opens a burst window after a hold-off equal to the sync width plus the breezeway. The window closes on the accumulator wrap that completes the required number of subcarrier cycles: 9 in the 525-line standard and 10 in the 625-line standard. Lines that start inside the vertical interval carry no burst. The block also outputs a V-axis sign for the 625-line standard. This sign flips at every line start. In the 525-line standard the sign output stays at zero, because that standard uses I/Q quadrature without alternation.

The sine lookup, the chroma modulator and the DAC sit downstream and take the phase word, the burst flag and the sign as inputs.

Top module: `chroma_sc_gate`

The burst window is a three-state machine. The states are GATE_IDLE (no burst), GATE_HOLDOFF (counting sample clocks after a line start) and GATE_BURST (counting subcarrier wraps). The transitions are:
- line start with vertical blanking active: any state to GATE_IDLE
- line start outside vertical blanking: any state to GATE_HOLDOFF
- hold-off count reached: GATE_HOLDOFF to GATE_BURST
- last wrap counted: GATE_BURST to GATE_IDLE

## Requirements
- R1: The output `sc_phase` is the top PH_W bits of an ACC_W-bit accumulator. The accumulator advances by the selected step on every clock after reset. After the first clock following reset, `sc_phase` equals the top bits of that step.
- R2: With `std_625` low, the step is round(315e6 * 2^ACC_W / (88 * CLK_HZ)).
- R3: With `std_625` high, the step is round(17734475 * 2^ACC_W / (4 * CLK_HZ)).
- R4: A line-start strobe leaves the accumulator untouched, so the phase keeps advancing by the step across the strobe.
- R5: On a line that starts outside vertical blanking, `burst_en` rises exactly D clocks after the edge that samples `line_stb`. D is round(CLK_HZ * (SYNC_NS + breezeway_ns) / 1e9). The breezeway is BRZ_NS_525 or BRZ_NS_625, chosen by the `std_625` value sampled together with the strobe.
- R6: `burst_en` falls at the clock edge where the accumulator wraps for the Nth time while in the burst state. N is CYC_525 (9) or CYC_625 (10).
- R7: If `vblank` is high when `line_stb` is sampled, `burst_en` stays low for the whole of that line.
- R8: A line-start strobe that arrives during hold-off or burst ends the current window and restarts the hold-off for the new line.
- R9: An internal sign bit flips on every sampled `line_stb`. `v_neg` shows this bit while `std_625` is high and is 0 while `std_625` is low.
- R10: While `rst_n` is low, `sc_phase`, `burst_en` and `v_neg` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-clock line-start strobe |
| std_625 | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| vblank | input | 1 | High while the raster is in the vertical interval |
| sc_phase | output | PH_W | Subcarrier phase word |
| burst_en | output | 1 | Burst window |
| v_neg | output | 1 | V-axis sign (1 = negative) |

## Verification
The bench builds the block with a 16-bit accumulator, an 8-bit phase word and a 27 MHz sample clock. With these values the oscillator wraps every six to eight clocks, and the hold-offs are 143 and 151 clocks. Every line therefore has a complete hold-off and burst within a few hundred cycles. Each cycle is compared against an arithmetic model: the accumulator sum, a clock count since the line start, and a wrap count. The sweep covers both standards, lines inside and outside vertical blanking, and lines cut short during the burst.

// File: rtl/chroma_sc_pkg.sv
package chroma_sc_pkg;

    typedef enum logic [1:0] {
        GATE_IDLE    = 2'd0,
        GATE_HOLDOFF = 2'd1,
        GATE_BURST   = 2'd2
    } gate_state_e;

    // Rounded num * 2^shift / den
    function automatic longint unsigned ratio_step(
        input longint unsigned num,
        input longint unsigned den,
        input int unsigned     shift
    );
        return ((num << shift) + den / 2) / den;
    endfunction

    // Rounded number of clocks in a span given in nanoseconds
    function automatic longint unsigned ns_to_clocks(
        input longint unsigned clk_hz,
        input longint unsigned ns
    );
        return (clk_hz * ns + 64'd500_000_000) / 64'd1_000_000_000;
    endfunction

    function automatic longint unsigned max2(
        input longint unsigned a,
        input longint unsigned b
    );
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sc_nco.sv
module sc_nco #(
    parameter int unsigned       ACC_W  = 32,
    parameter longint unsigned   STEP_A = 1,
    parameter longint unsigned   STEP_B = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_b,
    output logic [ACC_W-1:0] acc,
    output logic             wrap
);

    localparam logic [ACC_W-1:0] STEP_A_W = STEP_A[ACC_W-1:0];
    localparam logic [ACC_W-1:0] STEP_B_W = STEP_B[ACC_W-1:0];

    logic [ACC_W-1:0] step;
    logic [ACC_W:0]   sum;

    always_comb begin
        step = sel_b ? STEP_B_W : STEP_A_W;
        sum  = {1'b0, acc} + {1'b0, step};
        wrap = sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/burst_gate_fsm.sv
module burst_gate_fsm
    import chroma_sc_pkg::*;
#(
    parameter longint unsigned DLY_A = 143,
    parameter longint unsigned DLY_B = 151,
    parameter longint unsigned CYC_A = 9,
    parameter longint unsigned CYC_B = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic std_b,
    input  logic vblank,
    input  logic wrap,
    output logic burst_en
);

    localparam longint unsigned MAXV  = max2(max2(DLY_A, DLY_B), max2(CYC_A, CYC_B));
    localparam int unsigned     CNT_W = $clog2(MAXV + 1);
    localparam logic [CNT_W-1:0] DLY_A_LAST = CNT_W'(DLY_A - 1);
    localparam logic [CNT_W-1:0] DLY_B_LAST = CNT_W'(DLY_B - 1);
    localparam logic [CNT_W-1:0] CYC_A_LAST = CNT_W'(CYC_A - 1);
    localparam logic [CNT_W-1:0] CYC_B_LAST = CNT_W'(CYC_B - 1);

    gate_state_e      state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             line_std;
    logic [CNT_W-1:0] dly_last, cyc_last;

    always_comb begin
        dly_last = line_std ? DLY_B_LAST : DLY_A_LAST;
        cyc_last = line_std ? CYC_B_LAST : CYC_A_LAST;
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            GATE_IDLE:    nxt = GATE_IDLE;
            GATE_HOLDOFF: if (cnt == dly_last) nxt = GATE_BURST;
            GATE_BURST:   if (wrap && cnt == cyc_last) nxt = GATE_IDLE;
            default:      nxt = GATE_IDLE;
        endcase
        if (line_stb) begin
            nxt = vblank ? GATE_IDLE : GATE_HOLDOFF;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GATE_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Hold-off clocks and burst wraps share one counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            line_std <= 1'b0;
        end else if (line_stb) begin
            cnt      <= '0;
            line_std <= std_b;
        end else if (state == GATE_HOLDOFF) begin
            cnt <= (nxt == GATE_BURST) ? '0 : cnt + 1'b1;
        end else if (state == GATE_BURST && wrap) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        burst_en = (state == GATE_BURST);
    end

endmodule

// File: rtl/v_sign_toggle.sv
module v_sign_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic std_b,
    output logic v_neg
);

    logic flip;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flip <= 1'b0;
        end else if (line_stb) begin
            flip <= ~flip;
        end
    end

    always_comb begin
        v_neg = std_b & flip;
    end

endmodule

// File: rtl/chroma_sc_gate.sv
module chroma_sc_gate
    import chroma_sc_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 27_000_000,
    parameter int unsigned     ACC_W      = 32,
    parameter int unsigned     PH_W       = 12,
    parameter longint unsigned SYNC_NS    = 4700,
    parameter longint unsigned BRZ_NS_525 = 600,
    parameter longint unsigned BRZ_NS_625 = 900,
    parameter longint unsigned CYC_525    = 9,
    parameter longint unsigned CYC_625    = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_stb,
    input  logic            std_625,
    input  logic            vblank,
    output logic [PH_W-1:0] sc_phase,
    output logic            burst_en,
    output logic            v_neg
);

    localparam longint unsigned STEP_525 = ratio_step(64'd315_000_000, 64'd88 * CLK_HZ, ACC_W);
    localparam longint unsigned STEP_625 = ratio_step(64'd17_734_475, 64'd4 * CLK_HZ, ACC_W);
    localparam longint unsigned DLY_525  = ns_to_clocks(CLK_HZ, SYNC_NS + BRZ_NS_525);
    localparam longint unsigned DLY_625  = ns_to_clocks(CLK_HZ, SYNC_NS + BRZ_NS_625);

    logic [ACC_W-1:0] acc;
    logic             wrap;

    sc_nco #(
        .ACC_W  (ACC_W),
        .STEP_A (STEP_525),
        .STEP_B (STEP_625)
    ) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_b (std_625),
        .acc   (acc),
        .wrap  (wrap)
    );

    burst_gate_fsm #(
        .DLY_A (DLY_525),
        .DLY_B (DLY_625),
        .CYC_A (CYC_525),
        .CYC_B (CYC_625)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .std_b    (std_625),
        .vblank   (vblank),
        .wrap     (wrap),
        .burst_en (burst_en)
    );

    v_sign_toggle u_vsign (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .std_b    (std_625),
        .v_neg    (v_neg)
    );

    assign sc_phase = acc[ACC_W-1 -: PH_W];

endmodule

// File: rtl/chroma_sc_gate_chk.sv
module chroma_sc_gate_chk #(
    parameter int unsigned     PH_W    = 12,
    parameter longint unsigned DLY_525 = 143,
    parameter longint unsigned DLY_625 = 151
) (
    input logic            clk,
    input logic            rst_n,
    input logic            line_stb,
    input logic            std_625,
    input logic            vblank,
    input logic [PH_W-1:0] sc_phase,
    input logic            burst_en,
    input logic            v_neg
);

    logic [15:0] since_stb;
    logic        std_at_stb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_stb  <= '0;
            std_at_stb <= 1'b0;
        end else if (line_stb) begin
            since_stb  <= '0;
            std_at_stb <= std_625;
        end else if (since_stb != 16'hFFFF) begin
            since_stb <= since_stb + 16'd1;
        end
    end

    // R5: the window opens exactly the hold-off after the strobe
    a_r5_open_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_en) |-> (since_stb == (std_at_stb ? 16'(DLY_625) : 16'(DLY_525))));

    // R6: a window that ends without a new strobe ends on a phase wrap
    a_r6_close_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(burst_en) && !$past(line_stb)) |-> (sc_phase < $past(sc_phase)));

    // R7: a line starting in the vertical interval carries no burst
    a_r7_vblank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && vblank) |=> !burst_en);

    // R9: the sign is zero in the 525-line standard
    a_r9_no_sign_525: assert property (@(posedge clk) disable iff (!rst_n)
        !std_625 |-> !v_neg);

    // R9: the sign flips on each strobe in the 625-line standard
    a_r9_flip_625: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && std_625) |=> (!std_625 || (v_neg != $past(v_neg))));

endmodule

bind chroma_sc_gate chroma_sc_gate_chk #(
    .PH_W    (PH_W),
    .DLY_525 (DLY_525),
    .DLY_625 (DLY_625)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .std_625  (std_625),
    .vblank   (vblank),
    .sc_phase (sc_phase),
    .burst_en (burst_en),
    .v_neg    (v_neg)
);

// File: tb/test_chroma_sc_gate.sv
module test_chroma_sc_gate;

    localparam longint unsigned CLK_HZ = 27_000_000;
    localparam int unsigned     ACC_W  = 16;
    localparam int unsigned     PH_W   = 8;
    localparam longint unsigned STEP_A = ((64'd315_000_000 << ACC_W) + (64'd88 * CLK_HZ) / 2) / (64'd88 * CLK_HZ);
    localparam longint unsigned STEP_B = ((64'd17_734_475 << ACC_W) + (64'd4 * CLK_HZ) / 2) / (64'd4 * CLK_HZ);
    localparam longint unsigned DLY_A  = (CLK_HZ * 64'd5300 + 64'd500_000_000) / 64'd1_000_000_000;
    localparam longint unsigned DLY_B  = (CLK_HZ * 64'd5600 + 64'd500_000_000) / 64'd1_000_000_000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            line_stb = 1'b0;
    logic            std_625 = 1'b0;
    logic            vblank = 1'b0;
    logic [PH_W-1:0] sc_phase;
    logic            burst_en;
    logic            v_neg;

    int n_chk = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;

    always #10 clk = ~clk;

    chroma_sc_gate #(
        .CLK_HZ (CLK_HZ),
        .ACC_W  (ACC_W),
        .PH_W   (PH_W)
    ) i_chroma_sc_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .std_625  (std_625),
        .vblank   (vblank),
        .sc_phase (sc_phase),
        .burst_en (burst_en),
        .v_neg    (v_neg)
    );

    // Arithmetic model of the requirements
    logic [ACC_W-1:0] acc_m;
    logic [ACC_W:0]   sum_m;
    logic [15:0]      k_m;
    logic [7:0]       wc_m;
    logic             supp_m, std_l_m, started_m, cut_m, flip_m;
    longint unsigned  dly_m, cyc_m;
    logic             exp_burst;

    always_comb begin
        sum_m     = {1'b0, acc_m} + (std_625 ? (ACC_W+1)'(STEP_B) : (ACC_W+1)'(STEP_A));
        dly_m     = std_l_m ? DLY_B : DLY_A;
        cyc_m     = std_l_m ? 64'd10 : 64'd9;
        exp_burst = started_m && !supp_m && (64'(k_m) >= dly_m) && (64'(wc_m) < cyc_m);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            acc_m <= '0; k_m <= '0; wc_m <= '0; supp_m <= 1'b0;
            std_l_m <= 1'b0; started_m <= 1'b0; cut_m <= 1'b0; flip_m <= 1'b0;
        end else begin
            acc_m <= sum_m[ACC_W-1:0];
            if (line_stb) begin
                k_m <= '0; wc_m <= '0; supp_m <= vblank; std_l_m <= std_625;
                started_m <= 1'b1; cut_m <= exp_burst || (started_m && !supp_m && 64'(wc_m) < cyc_m);
                flip_m <= ~flip_m;
            end else begin
                if (k_m != 16'hFFFF) k_m <= k_m + 16'd1;
                if (sum_m[ACC_W] && 64'(k_m) >= dly_m && 64'(wc_m) < cyc_m) wc_m <= wc_m + 8'd1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, 5 ns after each rising edge
    always begin
        @(posedge clk);
        #5;
        if (chk_on) begin
            check(sc_phase == acc_m[ACC_W-1 -: PH_W],
                  (k_m == 0 && started_m) ? "R4" : (std_625 ? "R3" : "R2"),
                  "phase", sc_phase, acc_m[ACC_W-1 -: PH_W]);
            check(burst_en == exp_burst,
                  supp_m ? "R7" : (cut_m && 64'(k_m) < dly_m) ? "R8" : (64'(k_m) <= dly_m ? "R5" : "R6"),
                  "burst_en", burst_en, exp_burst);
            check(v_neg == (std_625 & flip_m), "R9", "v_neg", v_neg, std_625 & flip_m);
        end
    end

    task automatic run_line(input bit s, input bit vb, input int len);
        @(negedge clk);
        line_stb = 1'b1; std_625 = s; vblank = vb;
        @(negedge clk);
        line_stb = 1'b0;
        repeat (len - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset values
        check(sc_phase == 0, "R10", "phase in reset", sc_phase, 0);
        check(burst_en == 0, "R10", "burst_en in reset", burst_en, 0);
        check(v_neg == 0, "R10", "v_neg in reset", v_neg, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: one step after reset
        check(sc_phase == PH_W'(STEP_A >> (ACC_W - PH_W)), "R1", "first step",
              sc_phase, STEP_A >> (ACC_W - PH_W));
        chk_on = 1'b1;
        for (int rep = 0; rep < 2; rep++) begin
            for (int s = 0; s < 2; s++) begin
                for (int vb = 0; vb < 2; vb++) begin
                    run_line(s[0], vb[0], 300);
                    run_line(s[0], 1'b0, 290 + 7 * rep);
                end
            end
        end
        // R8: strobes arriving in the burst and in the hold-off
        run_line(1'b1, 1'b0, 170);
        run_line(1'b1, 1'b0, 300);
        run_line(1'b0, 1'b0, 100);
        run_line(1'b0, 1'b0, 165);
        run_line(1'b1, 1'b0, 300);
        run_line(1'b0, 1'b0, 300);
        @(negedge clk);
        chk_on = 1'b0;
        finish_run();
    end

endmodule